// File: doc/BRIEF.md
# DDR Command Timing Checker

This block is a passive monitor placed beside the command path of a four-bank DDR SDRAM. Every clock it looks at one already-decoded command (a 3-bit code), a bank number and the address bit that selects auto-precharge or all-bank precharge. It keeps its own model of which banks hold an open row and how long each inter-command spacing still has to run. When a command arrives too early, or reaches a bank in the wrong state, the block reports it one clock later as an error flag and a numeric code.

All spacings are parameters counted in clock cycles. The defaults describe a part run with a 7.5 ns clock: 3 cycles from activate to column access, 3 cycles of precharge, 2 cycles between activates to different banks, 9 cycles between activates to the same bank, 6 cycles of minimum row-open time, 2 cycles after a mode-register write, a write burst that starts 1 cycle after the command and lasts 2 cycles, a 2-cycle write recovery and 1 cycle from the last write data to a read. Any command the block flags is treated as never issued, so its model stays in step with what a correct controller would have done.

Top module: `ddr_cmd_timing_checker`

## Requirements
- R1: After reset the error flag and the code are 0 and every bank is closed, so a read to any bank right after reset is reported with code 8.
- R2: The result for a command driven in one cycle appears on the outputs after the next rising edge. Command code 0 (no operation) and code 7 (unused) are never flagged, and the code output is 0 whenever the flag is low.
- R3: A read (code 2) or write (code 3) to an open bank fewer than T_RCD cycles after that bank's activate (code 1) gives error code 1.
- R4: An activate to a bank fewer than T_RP cycles after a precharge (code 4) closed it gives error code 2; a refresh (code 5) or mode-register write (code 6) while any bank is still inside its precharge time also gives code 2.
- R5: An activate fewer than T_RRD cycles after an activate to a different bank gives error code 3.
- R6: An activate fewer than T_RC cycles after the previous activate to the same bank gives error code 4.
- R7: A precharge that would close a bank fewer than T_RAS cycles after its activate gives error code 5.
- R8: Any command other than codes 0 and 7 fewer than T_MRD cycles after a mode-register write gives error code 6.
- R9: A refresh or mode-register write while any bank is open gives error code 7.
- R10: A read or write to a closed bank gives error code 8; an activate to an open bank gives error code 9.
- R11: A read issued before T_WTR cycles have passed since the last data cycle of a write gives error code 10.
- R12: A read or write with the address bit high closes its bank at once; a new activate to it must wait WR_LAT+BURST_CYC-1+T_WR+T_RP cycles after a write (7 by default) or BURST_CYC+T_RP cycles after a read (5 by default), else code 2.
- R13: A precharge with the address bit high closes every open bank and ignores the bank number; a precharge to a bank that is already closed is harmless and starts no precharge time.
- R14: When several rules break at once the lowest code is reported, and a flagged command changes no bank state and no timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command: 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode-register write, 7 unused |
| bank_i | input | 2 | Bank addressed by the command |
| a10_i | input | 1 | Auto-precharge on read/write, all-bank select on precharge |
| err_flag_o | output | 1 | A rule was broken by the previous cycle's command |
| err_code_o | output | 4 | Lowest broken rule code, 0 when no error |

## Verification
The bench aims at the exact boundary cycle of each spacing, one cycle early and on time, since an off-by-one counter load would flag the legal cycle or pass the early one. It issues commands that break two rules at once (precharge time with row cycle time, closed bank with write-to-read) so a wrong priority shows up as the higher code. It follows rejected commands with ones that would only be legal if the rejection left the model untouched, and it precharges an idle bank before activating it, which a design that starts a precharge timer there would flag. Auto-precharge is checked both by a read to the just-closed bank and by activates at the read and write recovery boundaries.

// File: rtl/ddrchk_pkg.sv
package ddrchk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_RSV = 3'd7
  } ddr_cmd_e;

  // Rule index k reports code k+1; lower index wins.
  localparam int unsigned RULE_RCD    = 0;
  localparam int unsigned RULE_RP     = 1;
  localparam int unsigned RULE_RRD    = 2;
  localparam int unsigned RULE_RC     = 3;
  localparam int unsigned RULE_RAS    = 4;
  localparam int unsigned RULE_MRD    = 5;
  localparam int unsigned RULE_BUSY   = 6;
  localparam int unsigned RULE_CLOSED = 7;
  localparam int unsigned RULE_OPEN   = 8;
  localparam int unsigned RULE_WTR    = 9;
  localparam int unsigned NRULE       = 10;
  localparam int unsigned CODE_W      = 4;

endpackage

// File: rtl/ddrchk_bank.sv
module ddrchk_bank #(
  parameter int unsigned CW    = 4,
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RC  = 9,
  parameter int unsigned T_RAS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          shut_i,
  input  logic [CW-1:0] rp_load_i,
  output logic          open_o,
  output logic          rcd_busy_o,
  output logic          rp_busy_o,
  output logic          rc_busy_o,
  output logic          ras_busy_o
);

  localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] LD_RC  = CW'(T_RC - 1);
  localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);

  logic          open_q, open_d;
  logic [CW-1:0] rcd_q, rcd_d, rp_q, rp_d, rc_q, rc_d, ras_q, ras_d;
  logic          upd_en;

  always_comb begin
    open_d = open_q;
    rcd_d  = (rcd_q != '0) ? rcd_q - 1'b1 : rcd_q;
    rp_d   = (rp_q  != '0) ? rp_q  - 1'b1 : rp_q;
    rc_d   = (rc_q  != '0) ? rc_q  - 1'b1 : rc_q;
    ras_d  = (ras_q != '0) ? ras_q - 1'b1 : ras_q;
    if (act_i) begin
      open_d = 1'b1;
      rcd_d  = LD_RCD;
      rc_d   = LD_RC;
      ras_d  = LD_RAS;
    end else if (shut_i) begin
      open_d = 1'b0;
      rp_d   = rp_load_i;
    end
    upd_en = act_i | shut_i | (rcd_q != '0) | (rp_q != '0) |
             (rc_q != '0) | (ras_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      rp_q   <= '0;
      rc_q   <= '0;
      ras_q  <= '0;
    end else if (upd_en) begin
      open_q <= open_d;
      rcd_q  <= rcd_d;
      rp_q   <= rp_d;
      rc_q   <= rc_d;
      ras_q  <= ras_d;
    end
  end

  assign open_o     = open_q;
  assign rcd_busy_o = (rcd_q != '0);
  assign rp_busy_o  = (rp_q  != '0);
  assign rc_busy_o  = (rc_q  != '0);
  assign ras_busy_o = (ras_q != '0);

  // The top never opens and closes a bank in the same cycle.
  assert_no_clash_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_i, shut_i}));

  // An activate only reaches a closed bank.
  assert_act_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> !open_q);

  // Closing a bank always starts a precharge interval.
  assert_close_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_q) |-> (rp_q != '0));

endmodule

// File: rtl/ddrchk_global.sv
module ddrchk_global #(
  parameter int unsigned CW    = 4,
  parameter int unsigned BA_W  = 2,
  parameter int unsigned T_RRD = 2,
  parameter int unsigned T_MRD = 2,
  parameter int unsigned LD_WTR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_i,
  input  logic            mrs_i,
  input  logic            wr_i,
  input  logic [BA_W-1:0] bank_i,
  output logic            rrd_hit_o,
  output logic            mrd_busy_o,
  output logic            wtr_busy_o
);

  localparam logic [CW-1:0] LD_RRD = CW'(T_RRD - 1);
  localparam logic [CW-1:0] LD_MRD = CW'(T_MRD - 1);
  localparam logic [CW-1:0] LD_W2R = CW'(LD_WTR);

  logic [CW-1:0]   rrd_q, rrd_d, mrd_q, mrd_d, wtr_q, wtr_d;
  logic [BA_W-1:0] last_q, last_d;
  logic            upd_en;

  always_comb begin
    rrd_d  = (rrd_q != '0) ? rrd_q - 1'b1 : rrd_q;
    mrd_d  = (mrd_q != '0) ? mrd_q - 1'b1 : mrd_q;
    wtr_d  = (wtr_q != '0) ? wtr_q - 1'b1 : wtr_q;
    last_d = last_q;
    if (act_i) begin
      rrd_d  = LD_RRD;
      last_d = bank_i;
    end
    if (mrs_i) mrd_d = LD_MRD;
    if (wr_i)  wtr_d = LD_W2R;
    upd_en = act_i | mrs_i | wr_i | (rrd_q != '0) | (mrd_q != '0) |
             (wtr_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_q  <= '0;
      mrd_q  <= '0;
      wtr_q  <= '0;
      last_q <= '0;
    end else if (upd_en) begin
      rrd_q  <= rrd_d;
      mrd_q  <= mrd_d;
      wtr_q  <= wtr_d;
      last_q <= last_d;
    end
  end

  assign rrd_hit_o  = (rrd_q != '0) && (last_q != bank_i);
  assign mrd_busy_o = (mrd_q != '0);
  assign wtr_busy_o = (wtr_q != '0);

  // A mode-register write always leaves a wait window behind it.
  assert_mrs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mrs_i) |-> mrd_busy_o);

endmodule

// File: rtl/ddrchk_prio.sv
module ddrchk_prio #(
  parameter int unsigned NR = 10,
  parameter int unsigned CODE_W = 4
) (
  input  logic [NR-1:0]     hit_i,
  output logic [CODE_W-1:0] code_o
);

  always_comb begin
    code_o = '0;
    for (int k = NR - 1; k >= 0; k--) begin
      if (hit_i[k]) code_o = CODE_W'(k + 1);
    end
  end

endmodule

// File: rtl/ddr_cmd_timing_checker.sv
module ddr_cmd_timing_checker
  import ddrchk_pkg::*;
#(
  parameter int unsigned BA_W      = 2,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RRD     = 2,
  parameter int unsigned T_RC      = 9,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned T_WR      = 2,
  parameter int unsigned T_WTR     = 1,
  parameter int unsigned WR_LAT    = 1,
  parameter int unsigned BURST_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [BA_W-1:0]   bank_i,
  input  logic              a10_i,
  output logic              err_flag_o,
  output logic [CODE_W-1:0] err_code_o
);

  localparam int unsigned NBANK   = 1 << BA_W;
  localparam int unsigned LD_PRE  = T_RP - 1;
  localparam int unsigned LD_WRAP = WR_LAT + BURST_CYC + T_WR + T_RP - 2;
  localparam int unsigned LD_RDAP = BURST_CYC + T_RP - 1;
  localparam int unsigned LD_WTR  = WR_LAT + BURST_CYC + T_WTR - 2;
  localparam int unsigned M1 = (T_RC > LD_WRAP) ? T_RC : LD_WRAP;
  localparam int unsigned M2 = (M1 > LD_RDAP) ? M1 : LD_RDAP;
  localparam int unsigned M3 = (M2 > LD_WTR) ? M2 : LD_WTR;
  localparam int unsigned MAXLD = (M3 > T_RAS) ? M3 : T_RAS;
  localparam int unsigned CW = $clog2(MAXLD + 1);

  ddr_cmd_e cmd;
  logic is_act, is_rd, is_wr, is_pre, is_ref, is_mrs, is_real;
  logic [NBANK-1:0] open_v, rcd_v, rp_v, rc_v, ras_v, act_v, shut_v;
  logic [NRULE-1:0] hit;
  logic             any_hit, accept;
  logic [CW-1:0]    rp_load;
  logic             rrd_hit, mrd_busy, wtr_busy;
  logic [CODE_W-1:0] code_d;
  logic              flag_q;
  logic [CODE_W-1:0] code_q;

  assign cmd     = ddr_cmd_e'(cmd_i);
  assign is_act  = (cmd == CMD_ACT);
  assign is_rd   = (cmd == CMD_RD);
  assign is_wr   = (cmd == CMD_WR);
  assign is_pre  = (cmd == CMD_PRE);
  assign is_ref  = (cmd == CMD_REF);
  assign is_mrs  = (cmd == CMD_MRS);
  assign is_real = is_act | is_rd | is_wr | is_pre | is_ref | is_mrs;

  always_comb begin
    hit = '0;
    hit[RULE_RCD]    = (is_rd | is_wr) & open_v[bank_i] & rcd_v[bank_i];
    hit[RULE_RP]     = (is_act & rp_v[bank_i]) | ((is_ref | is_mrs) & (|rp_v));
    hit[RULE_RRD]    = is_act & rrd_hit;
    hit[RULE_RC]     = is_act & rc_v[bank_i];
    hit[RULE_RAS]    = is_pre & (a10_i ? |(open_v & ras_v)
                                       : (open_v[bank_i] & ras_v[bank_i]));
    hit[RULE_MRD]    = is_real & mrd_busy;
    hit[RULE_BUSY]   = (is_ref | is_mrs) & (|open_v);
    hit[RULE_CLOSED] = (is_rd | is_wr) & ~open_v[bank_i];
    hit[RULE_OPEN]   = is_act & open_v[bank_i];
    hit[RULE_WTR]    = is_rd & wtr_busy;
    any_hit = |hit;
    accept  = is_real & ~any_hit;
    if (is_pre)     rp_load = CW'(LD_PRE);
    else if (is_wr) rp_load = CW'(LD_WRAP);
    else            rp_load = CW'(LD_RDAP);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign act_v[b]  = accept & is_act & (bank_i == BA_W'(b));
    assign shut_v[b] = accept & (
                         (is_pre & open_v[b] & (a10_i | (bank_i == BA_W'(b)))) |
                         ((is_rd | is_wr) & a10_i & (bank_i == BA_W'(b))));
    ddrchk_bank #(
      .CW(CW), .T_RCD(T_RCD), .T_RC(T_RC), .T_RAS(T_RAS)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_i      (act_v[b]),
      .shut_i     (shut_v[b]),
      .rp_load_i  (rp_load),
      .open_o     (open_v[b]),
      .rcd_busy_o (rcd_v[b]),
      .rp_busy_o  (rp_v[b]),
      .rc_busy_o  (rc_v[b]),
      .ras_busy_o (ras_v[b])
    );
  end

  ddrchk_global #(
    .CW(CW), .BA_W(BA_W), .T_RRD(T_RRD), .T_MRD(T_MRD), .LD_WTR(LD_WTR)
  ) u_glob (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_i      (accept & is_act),
    .mrs_i      (accept & is_mrs),
    .wr_i       (accept & is_wr),
    .bank_i     (bank_i),
    .rrd_hit_o  (rrd_hit),
    .mrd_busy_o (mrd_busy),
    .wtr_busy_o (wtr_busy)
  );

  ddrchk_prio #(.NR(NRULE), .CODE_W(CODE_W)) u_prio (
    .hit_i  (hit),
    .code_o (code_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      code_q <= '0;
    end else begin
      flag_q <= any_hit;
      code_q <= code_d;
    end
  end

  assign err_flag_o = flag_q;
  assign err_code_o = code_q;

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_i) == 3'd0 || $past(cmd_i) == 3'd7) |-> !err_flag_o);

  assert_code_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !err_flag_o |-> (err_code_o == '0));

  assert_code_set_R14: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag_o |-> (err_code_o != '0));

  assert_single_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_v) <= 1);

endmodule

// File: tb/sim_ddr_cmd_timing_checker.sv
module sim_ddr_cmd_timing_checker;

  logic       clk;
  logic       rst_n;
  logic [2:0] cmd_i;
  logic [1:0] bank_i;
  logic       a10_i;
  logic       err_flag_o;
  logic [3:0] err_code_o;

  int n_chk;
  int n_bad;

  ddr_cmd_timing_checker u0 (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i),
    .a10_i(a10_i), .err_flag_o(err_flag_o), .err_code_o(err_code_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Entry: {cmd[2:0], bank[1:0], a10, expected code[3:0]}
  localparam int NV = 47;
  localparam logic [9:0] VEC [0:NV-1] = '{
    {3'd2, 2'd0, 1'b0, 4'd8},  // 0  read after reset, R1
    {3'd1, 2'd0, 1'b0, 4'd0},  // 1  activate b0
    {3'd1, 2'd1, 1'b0, 4'd3},  // 2  R5 too close
    {3'd2, 2'd0, 1'b0, 4'd1},  // 3  R3 one early
    {3'd2, 2'd0, 1'b0, 4'd0},  // 4  R3 on time
    {3'd1, 2'd1, 1'b0, 4'd0},  // 5  R14 rejected act at 2 left no trace
    {3'd4, 2'd0, 1'b0, 4'd5},  // 6  R7 one early
    {3'd4, 2'd0, 1'b0, 4'd0},  // 7  R7 on time
    {3'd1, 2'd0, 1'b0, 4'd2},  // 8  R4 and R6 both, R14 lowest wins
    {3'd0, 2'd0, 1'b0, 4'd0},  // 9
    {3'd1, 2'd0, 1'b0, 4'd0},  // 10 R4 on time
    {3'd3, 2'd1, 1'b0, 4'd0},  // 11 write b1
    {3'd2, 2'd1, 1'b0, 4'd10}, // 12 R11
    {3'd2, 2'd0, 1'b0, 4'd10}, // 13 R11 one early
    {3'd2, 2'd0, 1'b0, 4'd0},  // 14 R11 on time
    {3'd5, 2'd0, 1'b0, 4'd7},  // 15 R9 refresh
    {3'd6, 2'd0, 1'b0, 4'd7},  // 16 R9 mode write
    {3'd4, 2'd2, 1'b1, 4'd0},  // 17 R13 close all, bank ignored
    {3'd5, 2'd0, 1'b0, 4'd2},  // 18 R4 refresh in precharge
    {3'd0, 2'd0, 1'b0, 4'd0},  // 19
    {3'd6, 2'd0, 1'b0, 4'd0},  // 20 mode write
    {3'd1, 2'd2, 1'b0, 4'd6},  // 21 R8
    {3'd1, 2'd2, 1'b0, 4'd0},  // 22 R8 on time
    {3'd3, 2'd2, 1'b0, 4'd1},  // 23 R3 write
    {3'd0, 2'd0, 1'b0, 4'd0},  // 24
    {3'd3, 2'd2, 1'b1, 4'd0},  // 25 write with auto-precharge
    {3'd2, 2'd2, 1'b0, 4'd8},  // 26 R12 bank closed
    {3'd1, 2'd3, 1'b0, 4'd0},  // 27 activate b3
    {3'd0, 2'd0, 1'b0, 4'd0},  // 28
    {3'd0, 2'd0, 1'b0, 4'd0},  // 29
    {3'd2, 2'd3, 1'b1, 4'd0},  // 30 read with auto-precharge
    {3'd1, 2'd2, 1'b0, 4'd2},  // 31 R12 write recovery one early
    {3'd1, 2'd2, 1'b0, 4'd0},  // 32 R12 on time
    {3'd2, 2'd3, 1'b0, 4'd8},  // 33 R10 closed by auto-precharge
    {3'd0, 2'd0, 1'b0, 4'd0},  // 34
    {3'd1, 2'd3, 1'b0, 4'd4},  // 35 R6, precharge done
    {3'd1, 2'd3, 1'b0, 4'd0},  // 36 R6 on time
    {3'd0, 2'd0, 1'b0, 4'd0},  // 37
    {3'd0, 2'd0, 1'b0, 4'd0},  // 38
    {3'd0, 2'd0, 1'b0, 4'd0},  // 39
    {3'd0, 2'd0, 1'b0, 4'd0},  // 40
    {3'd1, 2'd2, 1'b0, 4'd9},  // 41 R10 activate open bank
    {3'd2, 2'd2, 1'b0, 4'd0},  // 42 read
    {3'd4, 2'd1, 1'b0, 4'd0},  // 43 R13 precharge idle bank
    {3'd1, 2'd1, 1'b0, 4'd0},  // 44 R13 no precharge time started
    {3'd7, 2'd1, 1'b0, 4'd0},  // 45 R2 unused code
    {3'd5, 2'd0, 1'b0, 4'd7}   // 46 R9
  };

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      4'd5: return "R7";
      4'd6: return "R8";
      4'd7: return "R9";
      4'd8, 4'd9: return "R10";
      4'd10: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] exp_code, input int idx);
    n_chk++;
    if (err_code_o !== exp_code || err_flag_o !== (exp_code != 4'd0)) begin
      n_bad++;
      $display("FAIL %s step %0d: flag=%0b code=%0d expected flag=%0b code=%0d",
               req, idx, err_flag_o, err_code_o, (exp_code != 4'd0), exp_code);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [1:0] b, input logic a);
    cmd_i  = c;
    bank_i = b;
    a10_i  = a;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    drive(3'd0, 2'd0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1", 4'd0, -1);           // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 4'd0, -1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) check(req_of(VEC[i-1][3:0]), VEC[i-1][3:0], i - 1);
      drive(VEC[i][9:7], VEC[i][6:5], VEC[i][4]);
    end
    @(negedge clk);
    check(req_of(VEC[NV-1][3:0]), VEC[NV-1][3:0], NV - 1);
    drive(3'd0, 2'd0, 1'b0);

    // R1: reset in mid-run closes banks and clears the outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 4'd0, 100);
    rst_n = 1'b1;
    drive(3'd2, 2'd2, 1'b0);
    @(negedge clk);
    check("R1", 4'd8, 101);

    // R13: close-all with each bank number gives the same result
    drive(3'd1, 2'd0, 1'b0);
    @(negedge clk);
    check("R13", 4'd0, 102);
    drive(3'd0, 2'd0, 1'b0);
    repeat (6) @(negedge clk);
    drive(3'd4, 2'd3, 1'b1);
    @(negedge clk);
    check("R13", 4'd0, 103);
    drive(3'd2, 2'd0, 1'b0);
    @(negedge clk);
    check("R13", 4'd8, 104);
    drive(3'd0, 2'd0, 1'b0);
    @(negedge clk);
    check("R2", 4'd0, 105);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule